// File: doc/BRIEF.md
# Prescaled 8-bit PWM Generator

This block produces one pulse-width-modulated output from a single 32-bit control word. The input clock is first slowed by a programmable divider. Each divided tick then advances an 8-bit period counter, so one output period is 256 ticks long. A compare value sets how much of each period the output spends low. The output is low at the start of the period and high for the rest of it.

Software writes the whole control word over a plain register port (write strobe, write data, read data). It reads the word back to perform read-modify-write updates. While running, divider and compare values written by software are held aside until the current period ends, so no period is ever cut short or stretched. While the channel is off, the output sits at a software-chosen idle level.

Top module: `pwm8_unit`

## Requirements
- R1: Bit 31 of the control word enables the channel. While it is 0, the divider and period counter are held at zero and the output does not toggle.
- R2: While bit 31 is 0, the output equals bit 30 (the idle level), and it follows that bit from the cycle after the write.
- R3: Bits 15:8 (reload R) set the clock divider. A value of 1 to 255 gives one tick every R clock cycles, and 0 gives one tick every 256 cycles.
- R4: The period counter advances by one on each tick and wraps from 255 to 0, so one output period lasts 256 ticks (256 x R clock cycles).
- R5: Bits 7:0 (compare N) shape each period. The output is low while the counter is below N and high from N through 255: N x R cycles low, then (256 - N) x R cycles high.
- R6: Reload and compare values written while bit 31 stays 1 do not affect the running period. They take effect at the next wrap from 255 to 0.
- R7: Each write stores all 32 bits, and the read port returns the last value written.
- R8: A synchronous active-low reset clears the control word, leaving the channel disabled with a low output and a read value of 0.
- R9: A write that sets bit 31 from 0 to 1 restarts the divider and counter from zero, using the fields of that same write. The output stays low for exactly N x R cycles after that write's clock edge.
- R10: Bits 29:16 are stored and read back but have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word read data |
| pwm_out | output | 1 | Modulated output |

## Verification
The waveform is measured over whole periods for several pairs of divider and compare values. Compare value 128 with divider 1 checks the plain case. A divider of 3 with compare 1, and a divider of 2 with compare 255, check the extreme compare values and that each counter step lasts exactly R cycles. A divider of 0 checks the divide-by-256 encoding, which no off-by-one in the divider could produce. A compare change written mid-period must leave the rest of that period alone and reshape only the following one. A disable in the middle of a period, followed by a re-enable, separates a true restart from a counter that merely resumes. Writes with the reserved bits set, and writes that only change the idle level, confirm that those bits have no effect and that the idle output tracks its bit.

// File: rtl/pwm8_pkg.sv
package pwm8_pkg;

   typedef enum logic {
      OUT_COMB = 1'b0,
      OUT_FLOP = 1'b1
   } out_mode_e;

   localparam int unsigned DEF_DATA_W     = 32;
   localparam int unsigned DEF_CNT_W      = 8;
   localparam int unsigned DEF_PRE_W      = 8;
   localparam int unsigned DEF_EN_POS     = 31;
   localparam int unsigned DEF_LVL_POS    = 30;
   localparam int unsigned DEF_RELOAD_LSB = 8;
   localparam int unsigned DEF_DUTY_LSB   = 0;

   function automatic bit fields_disjoint(int unsigned a_lsb, int unsigned a_w,
                                          int unsigned b_lsb, int unsigned b_w);
      return (a_lsb + a_w <= b_lsb) || (b_lsb + b_w <= a_lsb);
   endfunction

endpackage

// File: rtl/pwm8_cfg_reg.sv
module pwm8_cfg_reg #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned PRE_W      = 8,
   parameter int unsigned CNT_W      = 8,
   parameter int unsigned RELOAD_LSB = 8,
   parameter int unsigned DUTY_LSB   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] cfg_q,
   output logic [PRE_W-1:0]  nxt_reload,
   output logic [CNT_W-1:0]  nxt_duty
);

   logic [DATA_W-1:0] cfg_nxt;

   always_comb begin
      cfg_nxt = we ? wdata : cfg_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else begin
         cfg_q <= cfg_nxt;
      end
   end

   assign nxt_reload = cfg_nxt[RELOAD_LSB +: PRE_W];
   assign nxt_duty   = cfg_nxt[DUTY_LSB +: CNT_W];

endmodule

// File: rtl/pwm8_prescale.sv
module pwm8_prescale #(
   parameter int unsigned PRE_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [PRE_W-1:0] reload,
   output logic             tick
);

   localparam logic [PRE_W-1:0] PRE_ONE = PRE_W'(1);

   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] terminal;

   // reload of zero wraps to all-ones, giving the full 2**PRE_W divide
   assign terminal = reload - PRE_ONE;
   assign tick     = run && (pre_q == terminal);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pre_q <= '0;
      end else if (!run || tick) begin
         pre_q <= '0;
      end else begin
         pre_q <= pre_q + PRE_ONE;
      end
   end

endmodule

// File: rtl/pwm8_period_cnt.sv
module pwm8_period_cnt #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic [CNT_W-1:0] duty,
   output logic [CNT_W-1:0] cnt_q,
   output logic             wrap,
   output logic             cmp_hi
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   assign wrap   = tick && (cnt_q == CNT_MAX);
   assign cmp_hi = (cnt_q >= duty);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= cnt_q + CNT_ONE;
      end
   end

endmodule

// File: rtl/pwm8_unit.sv
module pwm8_unit
   import pwm8_pkg::*;
#(
   parameter int unsigned DATA_W     = DEF_DATA_W,
   parameter int unsigned CNT_W      = DEF_CNT_W,
   parameter int unsigned PRE_W      = DEF_PRE_W,
   parameter int unsigned EN_POS     = DEF_EN_POS,
   parameter int unsigned LVL_POS    = DEF_LVL_POS,
   parameter int unsigned RELOAD_LSB = DEF_RELOAD_LSB,
   parameter int unsigned DUTY_LSB   = DEF_DUTY_LSB,
   parameter out_mode_e   OUT_MODE   = OUT_COMB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   output logic              pwm_out
);

   localparam int unsigned RELOAD_MSB = RELOAD_LSB + PRE_W - 1;
   localparam int unsigned DUTY_MSB   = DUTY_LSB + CNT_W - 1;

   // elaboration-time parameter checks
   if (DATA_W != 32) begin : g_bad_data_w
      $error("pwm8_unit: DATA_W must match the 32-bit port");
   end
   if (CNT_W < 2 || PRE_W < 1) begin : g_bad_widths
      $error("pwm8_unit: counter or prescaler width too small");
   end
   if (EN_POS >= DATA_W || LVL_POS >= DATA_W || EN_POS == LVL_POS) begin : g_bad_ctl
      $error("pwm8_unit: control bit positions invalid");
   end
   if (RELOAD_MSB >= DATA_W || DUTY_MSB >= DATA_W) begin : g_bad_fields
      $error("pwm8_unit: field exceeds register width");
   end
   if (!fields_disjoint(RELOAD_LSB, PRE_W, DUTY_LSB, CNT_W) ||
       !fields_disjoint(RELOAD_LSB, PRE_W, EN_POS, 1) ||
       !fields_disjoint(RELOAD_LSB, PRE_W, LVL_POS, 1) ||
       !fields_disjoint(DUTY_LSB, CNT_W, EN_POS, 1) ||
       !fields_disjoint(DUTY_LSB, CNT_W, LVL_POS, 1)) begin : g_bad_overlap
      $error("pwm8_unit: register fields overlap");
   end

   logic [DATA_W-1:0] cfg_q;
   logic [PRE_W-1:0]  nxt_reload;
   logic [CNT_W-1:0]  nxt_duty;
   logic [PRE_W-1:0]  act_reload;
   logic [CNT_W-1:0]  act_duty;
   logic [CNT_W-1:0]  cnt_q;
   logic              run;
   logic              idle_lvl;
   logic              tick;
   logic              wrap;
   logic              cmp_hi;
   logic              out_nxt;

   pwm8_cfg_reg #(
      .DATA_W     (DATA_W),
      .PRE_W      (PRE_W),
      .CNT_W      (CNT_W),
      .RELOAD_LSB (RELOAD_LSB),
      .DUTY_LSB   (DUTY_LSB)
   ) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .we         (cfg_we),
      .wdata      (cfg_wdata),
      .cfg_q      (cfg_q),
      .nxt_reload (nxt_reload),
      .nxt_duty   (nxt_duty)
   );

   assign cfg_rdata = cfg_q;
   assign run       = cfg_q[EN_POS];
   assign idle_lvl  = cfg_q[LVL_POS];

   // active copies: follow the register while stopped, reload at each wrap
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_reload <= '0;
         act_duty   <= '0;
      end else if (!run) begin
         act_reload <= nxt_reload;
         act_duty   <= nxt_duty;
      end else if (wrap) begin
         act_reload <= cfg_q[RELOAD_LSB +: PRE_W];
         act_duty   <= cfg_q[DUTY_LSB +: CNT_W];
      end
   end

   pwm8_prescale #(
      .PRE_W  (PRE_W)
   ) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run),
      .reload (act_reload),
      .tick   (tick)
   );

   pwm8_period_cnt #(
      .CNT_W  (CNT_W)
   ) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run),
      .tick   (tick),
      .duty   (act_duty),
      .cnt_q  (cnt_q),
      .wrap   (wrap),
      .cmp_hi (cmp_hi)
   );

   assign out_nxt = run ? cmp_hi : idle_lvl;

   if (OUT_MODE == OUT_FLOP) begin : g_out_flop
      logic out_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            out_q <= 1'b0;
         end else begin
            out_q <= out_nxt;
         end
      end
      assign pwm_out = out_q;
   end else begin : g_out_comb
      assign pwm_out = out_nxt;
   end

endmodule

// File: rtl/pwm8_unit_chk.sv
module pwm8_unit_chk
   import pwm8_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned CNT_W    = 8,
   parameter int unsigned PRE_W    = 8,
   parameter int unsigned EN_POS   = 31,
   parameter int unsigned LVL_POS  = 30,
   parameter out_mode_e   OUT_MODE = OUT_COMB
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_we,
   input logic [31:0]       cfg_wdata,
   input logic [31:0]       cfg_rdata,
   input logic              pwm_out,
   input logic              run,
   input logic              tick,
   input logic              wrap,
   input logic [CNT_W-1:0]  cnt_q,
   input logic [CNT_W-1:0]  act_duty,
   input logic [PRE_W-1:0]  act_reload
);

   AST_STOPPED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (!run) |=> (cnt_q == '0 || run)); // R1

   AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !tick) |=> ($stable(cnt_q) || !run)); // R4

   AST_ACTIVE_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !wrap) |=> ($stable(act_duty) && $stable(act_reload))); // R6

   AST_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> (cfg_rdata == $past(cfg_wdata))); // R7

   AST_RESET_CLEAR: assert property (@(posedge clk)
      (!rst_n) |=> (cfg_rdata == '0)); // R8

   if (OUT_MODE == OUT_COMB) begin : g_idle_chk
      AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
         (!cfg_rdata[EN_POS]) |-> (pwm_out == cfg_rdata[LVL_POS])); // R2
   end

endmodule

bind pwm8_unit pwm8_unit_chk #(
   .DATA_W   (DATA_W),
   .CNT_W    (CNT_W),
   .PRE_W    (PRE_W),
   .EN_POS   (EN_POS),
   .LVL_POS  (LVL_POS),
   .OUT_MODE (OUT_MODE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_we     (cfg_we),
   .cfg_wdata  (cfg_wdata),
   .cfg_rdata  (cfg_rdata),
   .pwm_out    (pwm_out),
   .run        (run),
   .tick       (tick),
   .wrap       (wrap),
   .cnt_q      (cnt_q),
   .act_duty   (act_duty),
   .act_reload (act_reload)
);

// File: tb/sim_pwm8_unit.sv
module sim_pwm8_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        pwm_out;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   pwm8_unit u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .pwm_out   (pwm_out)
   );

   function automatic logic [31:0] mk(bit en, bit lvl, logic [13:0] rsv,
                                      logic [7:0] rel, logic [7:0] duty);
      return {en, lvl, rsv, rel, duty};
   endfunction

   task automatic chk(bit ok, string tag, longint act, longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   // one write; returns at the negedge just after the write edge (sample 0)
   task automatic wr(logic [31:0] v);
      @(negedge clk);
      cfg_we    = 1'b1;
      cfg_wdata = v;
      @(negedge clk);
      cfg_we    = 1'b0;
   endtask

   task automatic measure(int n, output int highs, output int first_hi);
      highs = 0;
      first_hi = -1;
      for (int i = 0; i < n; i++) begin
         if (pwm_out) begin
            highs++;
            if (first_hi < 0) first_hi = i;
         end
         @(negedge clk);
      end
   endtask

   task automatic t_reset();
      chk(cfg_rdata == 32'h0, "R8 reset readback", cfg_rdata, 0);
      chk(pwm_out == 1'b0, "R8 reset output low", pwm_out, 0);
   endtask

   task automatic t_idle();
      int highs, first;
      wr(mk(0, 1, 14'h0, 8'd5, 8'd9));
      chk(pwm_out == 1'b1, "R2 idle high", pwm_out, 1);
      chk(cfg_rdata == mk(0, 1, 14'h0, 8'd5, 8'd9), "R7 readback idle", cfg_rdata,
          mk(0, 1, 14'h0, 8'd5, 8'd9));
      measure(60, highs, first);
      chk(highs == 60, "R1 no toggle while disabled", highs, 60);
      wr(mk(0, 0, 14'h0, 8'd5, 8'd9));
      chk(pwm_out == 1'b0, "R2 idle low", pwm_out, 0);
   endtask

   task automatic t_run(logic [7:0] rel, logic [7:0] duty, string tag);
      int highs, first, div, per;
      div = (rel == 0) ? 256 : int'(rel);
      per = 256 * div;
      wr(mk(0, 0, 14'h0, rel, duty));
      wr(mk(1, 0, 14'h0, rel, duty));
      measure(per, highs, first);
      chk(first == int'(duty) * div, {tag, " first high"}, first, int'(duty) * div);
      chk(highs == (256 - int'(duty)) * div, {tag, " high count"}, highs,
          (256 - int'(duty)) * div);
   endtask

   task automatic t_reserved();
      int highs, first;
      logic [31:0] v;
      v = mk(1, 0, 14'h3FFF, 8'd1, 8'd64);
      wr(mk(0, 0, 14'h0, 8'd1, 8'd64));
      wr(v);
      chk(cfg_rdata == v, "R10 reserved bits read back", cfg_rdata, v);
      measure(256, highs, first);
      chk(first == 64 && highs == 192, "R10 reserved bits no effect", highs, 192);
   endtask

   task automatic t_update();
      int h1, h2, first2;
      h1 = 0; h2 = 0; first2 = -1;
      wr(mk(0, 0, 14'h0, 8'd1, 8'd64));
      wr(mk(1, 0, 14'h0, 8'd1, 8'd64));
      for (int i = 0; i < 512; i++) begin
         if (i == 100) begin
            cfg_we = 1'b1;
            cfg_wdata = mk(1, 0, 14'h0, 8'd1, 8'd192);
         end else if (i == 101) begin
            cfg_we = 1'b0;
         end
         if (pwm_out) begin
            if (i < 256) h1++;
            else begin
               h2++;
               if (first2 < 0) first2 = i - 256;
            end
         end
         @(negedge clk);
      end
      chk(h1 == 192, "R6 running period unchanged", h1, 192);
      chk(first2 == 192, "R6 new compare at wrap first high", first2, 192);
      chk(h2 == 64, "R6 new compare at wrap high count", h2, 64);
   endtask

   task automatic t_restart();
      int highs, first;
      wr(mk(0, 0, 14'h0, 8'd1, 8'd128));
      wr(mk(1, 0, 14'h0, 8'd1, 8'd128));
      repeat (150) @(negedge clk);
      chk(pwm_out == 1'b1, "R5 high after compare", pwm_out, 1);
      wr(mk(0, 1, 14'h0, 8'd1, 8'd128));
      chk(pwm_out == 1'b1, "R2 idle high after mid-run disable", pwm_out, 1);
      wr(mk(0, 0, 14'h0, 8'd1, 8'd128));
      measure(40, highs, first);
      chk(highs == 0, "R1 stopped output static", highs, 0);
      wr(mk(1, 0, 14'h0, 8'd1, 8'd128));
      measure(256, highs, first);
      chk(first == 128, "R9 restart from zero", first, 128);
      chk(highs == 128, "R9 restart period", highs, 128);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_idle();
      t_run(8'd1, 8'd128, "R5 R4 div1 duty128");
      t_run(8'd3, 8'd1, "R3 div3 duty1");
      t_run(8'd2, 8'd255, "R5 div2 duty255");
      t_run(8'd0, 8'd200, "R3 div256 duty200");
      t_reserved();
      t_update();
      t_restart();
      wr(32'h0);
      chk(cfg_rdata == 32'h0 && pwm_out == 1'b0, "R7 final clear", cfg_rdata, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL R4 watchdog expired act=%0d exp=%0d", 200000, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule